// File: doc/BRIEF.md
# Compare-and-Branch Resolution Unit

This unit settles conditional branches for a core whose compare instruction records no flags. A compare strobe copies two register values verbatim into a pair of operand registers. Each later conditional branch names one of ten relations between those stored operands. The relations cover equality, signed order and unsigned order. The unit then reports whether the branch is taken and which program counter comes next.

Branch requests arrive on a valid/ready channel. A request is accepted in a cycle where `br_valid` and `br_ready` are both high. `br_ready` is high whenever the one-entry result register is empty, or is being emptied in that same cycle (`res_ready` high). The result comes out on a valid/ready channel. While `res_valid` is high and `res_ready` is low, the result stays frozen and no new branch is accepted. The compare strobe is a plain control pin: it is taken every cycle it is high and never stalls.

Condition codes 10 to 15 are undefined. A branch that carries one of them is flagged illegal. Its next PC is left on the faulting instruction, so that a trap handler sees the right address.

Top module: `cbr_unit`

## Requirements
- R1: After reset, both stored operands are zero, `res_valid` is low and `br_ready` is high.
- R2: A cycle with `cmp_valid` high stores `cmp_a` and `cmp_b` unchanged. The stored pair then stays the same through any number of branches and idle cycles until the next compare strobe.
- R3: Condition code 0 is taken when the stored A equals the stored B. Code 1 is taken when they differ.
- R4: The signed relations use two's complement and compare A against B. Code 2 is A<B. Code 3 is A>B. Code 6 is A>=B. Code 7 is A<=B.
- R5: The unsigned relations compare A against B. Code 4 is A<B. Code 5 is A>B. Code 8 is A>=B. Code 9 is A<=B.
- R6: A taken branch gives next PC = PC + 2 + D. D is the 10-bit `br_ofs` field (bit 9 is the sign) sign-extended to 32 bits and then shifted left by one. The addition wraps modulo 2^32.
- R7: A legal branch that is not taken gives next PC = PC + 2, with `res_taken` low.
- R8: Condition codes 10 through 15 give `res_illegal` high, `res_taken` low and next PC equal to the branch's own PC. Legal codes give `res_illegal` low.
- R9: The result of a branch accepted at one clock edge shows on the outputs right after that edge, with `res_valid` high. It stays unchanged while `res_ready` is low. `res_valid` falls after an edge where `res_ready` was high and no branch was accepted.
- R10: `br_ready` equals (not `res_valid`) or `res_ready`.
- R11: When a compare strobe and an accepted branch fall in the same cycle, the branch is resolved against the operands stored before that cycle. The new pair applies from the next branch onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmp_valid | input | 1 | Compare strobe |
| cmp_a | input | 32 | First compare operand |
| cmp_b | input | 32 | Second compare operand |
| br_valid | input | 1 | Branch request valid |
| br_ready | output | 1 | Branch request can be accepted |
| br_pc | input | 32 | Address of the branch instruction |
| br_cond | input | 4 | Relation selector, codes 0 to 15 |
| br_ofs | input | 10 | Signed halfword displacement field |
| res_valid | output | 1 | Resolution result valid |
| res_ready | input | 1 | Consumer takes the result |
| res_taken | output | 1 | Branch taken |
| res_illegal | output | 1 | Undefined condition code |
| res_next_pc | output | 32 | Next program counter |

## Verification
The assertions assume that reset is held for at least one clock edge before any strobe. They also assume that `br_pc`, `br_cond` and `br_ofs` are known whenever `br_valid` is high. The bench drives every input a fixed time after the falling edge, so every sampled value is stable and defined. It holds reset for several cycles first. Its random phase can drop `res_ready` or `br_valid` in any cycle. Stalls therefore land in the middle of a pending result, and the bench does not pace its input to match the unit.

// File: rtl/cbr_pkg.sv
package cbr_pkg;

  localparam int unsigned CODE_W    = 4;
  localparam int unsigned NUM_LEGAL = 10;

  typedef enum logic [CODE_W-1:0] {
    REL_EQ  = 4'd0,
    REL_NE  = 4'd1,
    REL_SLT = 4'd2,
    REL_SGT = 4'd3,
    REL_ULT = 4'd4,
    REL_UGT = 4'd5,
    REL_SGE = 4'd6,
    REL_SLE = 4'd7,
    REL_UGE = 4'd8,
    REL_ULE = 4'd9
  } rel_code_e;

  typedef struct packed {
    logic eq;
    logic slt;
    logic ult;
  } rel_basis_t;

  typedef struct packed {
    logic taken;
    logic illegal;
  } verdict_t;

  function automatic logic rel_hit(input int unsigned code, input rel_basis_t b);
    logic r;
    case (code)
      REL_EQ:  r = b.eq;
      REL_NE:  r = !b.eq;
      REL_SLT: r = b.slt;
      REL_SGT: r = !b.slt && !b.eq;
      REL_ULT: r = b.ult;
      REL_UGT: r = !b.ult && !b.eq;
      REL_SGE: r = !b.slt;
      REL_SLE: r = b.slt || b.eq;
      REL_UGE: r = !b.ult;
      REL_ULE: r = b.ult || b.eq;
      default: r = 1'b0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/cbr_operand_store.sv
module cbr_operand_store #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] a_in,
  input  logic [DATA_W-1:0] b_in,
  output logic [DATA_W-1:0] a_q,
  output logic [DATA_W-1:0] b_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_q <= '0;
      b_q <= '0;
    end else if (load) begin
      a_q <= a_in;
      b_q <= b_in;
    end
  end

  AST_OPERAND_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> ($stable(a_q) && $stable(b_q))); // R2

endmodule

// File: rtl/cbr_cond_eval.sv
module cbr_cond_eval
  import cbr_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned COND_W = 4
) (
  input  logic [DATA_W-1:0] op_a,
  input  logic [DATA_W-1:0] op_b,
  input  logic [COND_W-1:0] cond,
  output verdict_t          verdict
);

  localparam int unsigned NUM_CODES = 1 << COND_W;

  rel_basis_t           basis;
  logic [NUM_CODES-1:0] hit;
  logic [NUM_CODES-1:0] legal;

  always_comb begin
    basis.eq  = (op_a == op_b);
    basis.ult = (op_a < op_b);
    basis.slt = ($signed(op_a) < $signed(op_b));
  end

  for (genvar k = 0; k < NUM_CODES; k++) begin : g_code
    if (k < NUM_LEGAL) begin : g_legal
      assign hit[k]   = rel_hit(k, basis);
      assign legal[k] = 1'b1;
    end else begin : g_reserved
      assign hit[k]   = 1'b0;
      assign legal[k] = 1'b0;
    end
  end

  always_comb begin
    verdict.taken   = hit[cond];
    verdict.illegal = !legal[cond];
  end

endmodule

// File: rtl/cbr_target_calc.sv
module cbr_target_calc #(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned OFS_W      = 10,
  parameter int unsigned STEP_BYTES = 2
) (
  input  logic [ADDR_W-1:0] pc,
  input  logic [OFS_W-1:0]  ofs,
  input  logic              taken,
  input  logic              illegal,
  output logic [ADDR_W-1:0] next_pc
);

  localparam int unsigned EXT_W = ADDR_W - OFS_W - 1;

  logic [ADDR_W-1:0] disp;
  logic [ADDR_W-1:0] seq_pc;
  logic [ADDR_W-1:0] tgt_pc;

  always_comb begin
    disp   = {{EXT_W{ofs[OFS_W-1]}}, ofs, 1'b0};
    seq_pc = pc + ADDR_W'(STEP_BYTES);
    tgt_pc = seq_pc + disp;
    if (illegal)    next_pc = pc;
    else if (taken) next_pc = tgt_pc;
    else            next_pc = seq_pc;
  end

endmodule

// File: rtl/cbr_unit.sv
module cbr_unit
  import cbr_pkg::*;
#(
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned COND_W     = 4,
  parameter int unsigned OFS_W      = 10,
  parameter int unsigned STEP_BYTES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmp_valid,
  input  logic [DATA_W-1:0] cmp_a,
  input  logic [DATA_W-1:0] cmp_b,
  input  logic              br_valid,
  output logic              br_ready,
  input  logic [ADDR_W-1:0] br_pc,
  input  logic [COND_W-1:0] br_cond,
  input  logic [OFS_W-1:0]  br_ofs,
  output logic              res_valid,
  input  logic              res_ready,
  output logic              res_taken,
  output logic              res_illegal,
  output logic [ADDR_W-1:0] res_next_pc
);

  localparam logic [COND_W-1:0] FIRST_RESERVED = COND_W'(NUM_LEGAL);

  logic [DATA_W-1:0] op_a;
  logic [DATA_W-1:0] op_b;
  verdict_t          verdict;
  logic [ADDR_W-1:0] next_pc_d;
  logic              accept;

  cbr_operand_store #(.DATA_W(DATA_W)) u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (cmp_valid),
    .a_in  (cmp_a),
    .b_in  (cmp_b),
    .a_q   (op_a),
    .b_q   (op_b)
  );

  cbr_cond_eval #(.DATA_W(DATA_W), .COND_W(COND_W)) u_eval (
    .op_a    (op_a),
    .op_b    (op_b),
    .cond    (br_cond),
    .verdict (verdict)
  );

  cbr_target_calc #(.ADDR_W(ADDR_W), .OFS_W(OFS_W), .STEP_BYTES(STEP_BYTES)) u_tgt (
    .pc      (br_pc),
    .ofs     (br_ofs),
    .taken   (verdict.taken),
    .illegal (verdict.illegal),
    .next_pc (next_pc_d)
  );

  assign br_ready = !res_valid || res_ready;
  assign accept   = br_valid && br_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid   <= 1'b0;
      res_taken   <= 1'b0;
      res_illegal <= 1'b0;
      res_next_pc <= '0;
    end else if (accept) begin
      res_valid   <= 1'b1;
      res_taken   <= verdict.taken;
      res_illegal <= verdict.illegal;
      res_next_pc <= next_pc_d;
    end else if (res_ready) begin
      res_valid   <= 1'b0;
    end
  end

  AST_RESULT_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (br_valid && br_ready) |=> res_valid); // R9
  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_next_pc)
      && $stable(res_taken) && $stable(res_illegal))); // R9
  AST_READY_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> br_ready); // R10
  AST_ILLEGAL_NOT_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_illegal) |-> !res_taken); // R8
  AST_ILLEGAL_PC_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (br_valid && br_ready && br_cond >= FIRST_RESERVED)
      |=> (res_illegal && res_next_pc == $past(br_pc))); // R8
  AST_FALLTHROUGH_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (br_valid && br_ready) |=> (res_illegal || res_taken
      || res_next_pc == $past(br_pc) + ADDR_W'(STEP_BYTES))); // R7

endmodule

// File: tb/cbr_unit_tb.sv
module cbr_unit_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmp_valid = 1'b0;
  logic [31:0] cmp_a = '0;
  logic [31:0] cmp_b = '0;
  logic        br_valid = 1'b0;
  logic        br_ready;
  logic [31:0] br_pc = '0;
  logic [3:0]  br_cond = '0;
  logic [9:0]  br_ofs = '0;
  logic        res_valid;
  logic        res_ready = 1'b1;
  logic        res_taken;
  logic        res_illegal;
  logic [31:0] res_next_pc;

  always #2 clk = ~clk;

  cbr_unit u_dut (
    .clk(clk), .rst_n(rst_n), .cmp_valid(cmp_valid), .cmp_a(cmp_a), .cmp_b(cmp_b),
    .br_valid(br_valid), .br_ready(br_ready), .br_pc(br_pc), .br_cond(br_cond),
    .br_ofs(br_ofs), .res_valid(res_valid), .res_ready(res_ready),
    .res_taken(res_taken), .res_illegal(res_illegal), .res_next_pc(res_next_pc)
  );

  int    n_total = 0;
  int    n_bad   = 0;
  bit    done    = 0;
  string phase   = "R1";

  // Behavioural reference state
  logic [31:0] m_a = '0, m_b = '0;
  bit          m_valid = 0, m_taken = 0, m_illegal = 0;
  logic [31:0] m_pc = '0;
  int          m_cond = 0;
  string       m_phase = "R1";

  function automatic bit rel(int code, logic [31:0] a, logic [31:0] b);
    case (code)
      0: return a == b;
      1: return a != b;
      2: return $signed(a) <  $signed(b);
      3: return $signed(a) >  $signed(b);
      4: return a <  b;
      5: return a >  b;
      6: return $signed(a) >= $signed(b);
      7: return $signed(a) <= $signed(b);
      8: return a >= b;
      9: return a <= b;
      default: return 0;
    endcase
  endfunction

  function automatic string cond_tag(int code);
    if (code <= 1) return "R3";
    if (code == 2 || code == 3 || code == 6 || code == 7) return "R4";
    if (code <= 9) return "R5";
    return "R8";
  endfunction

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    n_total++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s [%s] %s actual=%h expected=%h", req, m_phase, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_a = '0; m_b = '0; m_valid = 0;
    end else begin
      if (br_valid && (!m_valid || res_ready)) begin
        m_valid   = 1;
        m_cond    = int'(br_cond);
        m_phase   = phase;
        m_illegal = (br_cond >= 4'd10);
        m_taken   = rel(m_cond, m_a, m_b);
        if (m_illegal)    m_pc = br_pc;
        else if (m_taken) m_pc = br_pc + 32'd2 + ({{22{br_ofs[9]}}, br_ofs} << 1);
        else              m_pc = br_pc + 32'd2;
      end else if (res_ready) begin
        m_valid = 0;
      end
      if (cmp_valid) begin
        m_a = cmp_a; m_b = cmp_b;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(res_valid == m_valid, "R9", "res_valid", 32'(res_valid), 32'(m_valid));
      chk(br_ready == (!m_valid || res_ready), "R10", "br_ready", 32'(br_ready),
          32'(!m_valid || res_ready));
      if (m_valid && res_valid) begin
        chk(res_taken == m_taken, cond_tag(m_cond), "res_taken", 32'(res_taken), 32'(m_taken));
        chk(res_illegal == m_illegal, "R8", "res_illegal", 32'(res_illegal), 32'(m_illegal));
        chk(res_next_pc == m_pc, m_illegal ? "R8" : (m_taken ? "R6" : "R7"),
            "res_next_pc", res_next_pc, m_pc);
      end
    end
  end

  task automatic step(bit cv, logic [31:0] a, logic [31:0] b, bit bv,
                      logic [31:0] pc, logic [3:0] cc, logic [9:0] ofs, bit rr);
    @(negedge clk); #1;
    cmp_valid = cv; cmp_a = a; cmp_b = b;
    br_valid = bv; br_pc = pc; br_cond = cc; br_ofs = ofs; res_ready = rr;
  endtask

  task automatic sweep(logic [31:0] a, logic [31:0] b, logic [31:0] pc, logic [9:0] ofs);
    step(1, a, b, 0, 0, 0, 0, 1);
    for (int c = 0; c < 16; c++) step(0, 0, 0, 1, pc + 32'(c * 8), 4'(c), ofs, 1);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    phase = "R1";
    chk(res_valid == 0 && br_ready == 1, "R1", "post-reset valid/ready",
        {30'd0, res_valid, br_ready}, 32'd1);
    step(0, 0, 0, 1, 32'h100, 4'd0, 10'd4, 1);   // zero operands: EQ taken
    step(0, 0, 0, 0, 0, 0, 0, 1);
    chk(res_taken == 1 && res_next_pc == 32'h10A, "R1", "EQ on reset operands",
        res_next_pc, 32'h10A);

    phase = "R3";
    sweep(32'h1234, 32'h1234, 32'h2000, 10'h010);
    phase = "R4";
    sweep(32'hFFFF_FFF0, 32'h0000_0005, 32'h3000, 10'h3F0);
    sweep(32'h7FFF_FFFF, 32'h8000_0000, 32'h3400, 10'h001);
    phase = "R5";
    sweep(32'h0000_0001, 32'hFFFF_FFFF, 32'h4000, 10'h1FF);
    sweep(32'hFFFF_FFFF, 32'h0000_0001, 32'h4400, 10'h200);

    phase = "R6";
    step(1, 5, 5, 0, 0, 0, 0, 1);
    step(0, 0, 0, 1, 32'h0000_0000, 4'd0, 10'h200, 1);  // most negative
    step(0, 0, 0, 1, 32'hFFFF_FFFE, 4'd0, 10'h1FF, 1);  // wraps forward
    step(0, 0, 0, 1, 32'h0000_5000, 4'd0, 10'h3FF, 1);  // -2 bytes: self
    step(0, 0, 0, 1, 32'hFFFF_FFFE, 4'd1, 10'h000, 1);  // not taken wraps
    phase = "R8";
    step(0, 0, 0, 1, 32'h0000_6000, 4'd10, 10'h010, 1);
    step(0, 0, 0, 1, 32'h0000_6002, 4'd15, 10'h3FF, 1);

    phase = "R9";
    step(0, 0, 0, 1, 32'h7000, 4'd0, 10'h002, 0);
    step(0, 0, 0, 1, 32'h7100, 4'd1, 10'h002, 0);
    step(0, 0, 0, 1, 32'h7100, 4'd1, 10'h002, 0);
    step(0, 0, 0, 1, 32'h7100, 4'd1, 10'h002, 1);
    step(0, 0, 0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 0, 1);

    phase = "R11";
    step(1, 32'd1, 32'd2, 0, 0, 0, 0, 1);
    step(1, 32'd9, 32'd9, 1, 32'h8000, 4'd0, 10'h004, 1); // old 1 vs 2: EQ not taken
    step(0, 0, 0, 1, 32'h8010, 4'd0, 10'h004, 1);         // new 9 vs 9: taken

    phase = "R2";
    for (int i = 0; i < 6; i++)
      step(0, 32'(i * 77), 32'(i * 3), 1, 32'h9000 + 32'(i * 2), 4'd0, 10'h008, 1);

    phase = "random";
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] ra, rb;
      ra = $urandom();
      rb = ($urandom_range(0, 3) == 0) ? ra : $urandom();
      step($urandom_range(0, 3) == 0, ra, rb, $urandom_range(0, 3) != 0, $urandom(),
           4'($urandom_range(0, 15)), 10'($urandom()), $urandom_range(0, 3) != 0);
    end
    step(0, 0, 0, 0, 0, 0, 0, 1);
    step(0, 0, 0, 0, 0, 0, 0, 1);
    @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", n_total, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_total++;
      n_bad++;
      $display("FAIL R9 watchdog expired actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", n_total, n_bad);
      $finish;
    end
  end

endmodule